// File: doc/BRIEF.md
# Flash Write/Erase Control and Status Register

This block is the single byte-wide control and status register that software uses to drive an embedded flash write/erase engine. It sits on a simple register bus, with an address, write data, write and read strobes, and a qualifier that marks the read half of a read-modify-write access. It holds an interrupt enable, a sticky completion flag, a write enable and four general-purpose bits. It also shows the flash engine's live ready level.

On the flash side the block takes a one-cycle pulse that marks the end of the programming algorithm. It produces a level interrupt request and a gated write/erase strobe. A bus write becomes a flash strobe only under three conditions: the write enable is set, the target address lies in the flash bank window, and no earlier operation is still waiting for completion. Issuing a strobe clears the completion flag. The flag is set again when the completion pulse arrives.

The read value substitutes a 1 for the completion flag during read-modify-write reads. A bit operation on another field then writes the flag back as 1, and that write has no effect on the flag.

Top module: `flash_ctl_status`

## Requirements
- R1: After reset, a read of the register returns 0 in every bit except bit 4, and both `irq` and `flash_we` are 0.
- R2: A write at the register address stores bit 7 as the interrupt enable, bit 5 as the write enable and bits 3..0 as general-purpose bits. A later read returns them in the same positions.
- R3: Read bit 4 always equals the current `flash_ready` input, and writes to bit 4 have no effect on it.
- R4: A cycle with `alg_done` high sets the completion flag (read bit 6) from the next cycle on.
- R5: Writing 0 in bit 6 clears the completion flag. Writing 1 in bit 6 leaves it unchanged.
- R6: During a read with `bus_rmw` high, bit 6 reads as 1 whatever the flag holds. All other bits read as usual.
- R7: `irq` is 1 exactly when the interrupt enable and the completion flag are both 1.
- R8: `flash_we` is high, in the same cycle as `bus_wr`, only when three conditions hold: the write enable is 1, the address bank `bus_addr[23:16]` is in 0xF8..0xFF, and no operation is pending. It is never high while the write enable is 0.
- R9: After a strobe has been issued, further bank writes produce no strobe until `alg_done` has been seen.
- R10: When `alg_done` and a register write of 0 in bit 6 fall in the same cycle, the completion flag ends up set.
- R11: Writes to any address other than `REG_ADDR` (default 0x0000AE) leave the register unchanged. Reads of other addresses, and cycles without `bus_rd`, return 0.
- R12: Issuing a strobe clears the completion flag from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read is part of a read-modify-write |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| alg_done | input | 1 | One-cycle end-of-algorithm pulse |
| flash_ready | input | 1 | Live ready level from the flash engine |
| irq | output | 1 | Level interrupt request |
| flash_we | output | 1 | Gated write/erase strobe to the flash |

## Verification
The register is swept through all 256 write values twice. The first pass starts with the flag set, which separates clear-on-0 from ignore-on-1. The second pass starts with the flag clear, which shows that a written 1 cannot set it. Each value is read back both plainly and as a read-modify-write read, which tells the forced bit 6 apart from the stored flag. The flash strobe is swept over all 256 banks with the enable off and on. Every strobe that fires is followed by a repeated write, to show blocking, and then by a completion pulse. Single-bit address flips and a completion pulse that collides with a clearing write cover decode and priority.

// File: rtl/flcs_pkg.sv
package flcs_pkg;
  localparam int DATA_W   = 8;
  localparam int RSV_W    = 4;
  localparam int B_IE     = 7;
  localparam int B_FLAG   = 6;
  localparam int B_WE     = 5;
  localparam int B_READY  = 4;

  typedef struct packed {
    logic             ie;
    logic             flag;
    logic             we;
    logic [RSV_W-1:0] rsv;
  } ctl_t;

  // assemble the byte seen by software
  function automatic logic [DATA_W-1:0] pack_status(ctl_t c, logic ready, logic rmw);
    logic [DATA_W-1:0] v;
    v          = '0;
    v[B_IE]    = c.ie;
    v[B_FLAG]  = c.flag | rmw;
    v[B_WE]    = c.we;
    v[B_READY] = ready;
    v[RSV_W-1:0] = c.rsv;
    return v;
  endfunction

  function automatic logic in_window(logic [7:0] bank, logic [7:0] lo, logic [7:0] hi);
    return (bank >= lo) && (bank <= hi);
  endfunction
endpackage

// File: rtl/flcs_decode.sv
module flcs_decode #(
  parameter int          ADDR_W   = 24,
  parameter logic [23:0] REG_ADDR = 24'h0000AE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit_wr,
  output logic              hit_rd
);
  logic sel;
  assign sel    = (addr == REG_ADDR[ADDR_W-1:0]);
  assign hit_wr = sel && wr;
  assign hit_rd = sel && rd;
endmodule

// File: rtl/flcs_gate.sv
module flcs_gate #(
  parameter int         BANK_W  = 8,
  parameter logic [7:0] BANK_LO = 8'hF8,
  parameter logic [7:0] BANK_HI = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              wr,
  input  logic              we_en,
  input  logic              busy,
  output logic              start
);
  logic in_flash;
  assign in_flash = flcs_pkg::in_window(bank, BANK_LO, BANK_HI);
  assign start    = wr && in_flash && we_en && !busy;

  // R8
  flash_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (bank >= BANK_LO && bank <= BANK_HI && we_en));
endmodule

// File: rtl/flcs_regs.sv
module flcs_regs
  import flcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              alg_done,
  input  logic              start,
  output ctl_t              ctl_q,
  output logic              busy_q
);
  logic sw_clr;
  assign sw_clr = hit_wr && !wdata[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (hit_wr) begin
        ctl_q.ie  <= wdata[B_IE];
        ctl_q.we  <= wdata[B_WE];
        ctl_q.rsv <= wdata[RSV_W-1:0];
      end
      if (alg_done)                ctl_q.flag <= 1'b1;
      else if (start || sw_clr)    ctl_q.flag <= 1'b0;
      if (start)                   busy_q <= 1'b1;
      else if (alg_done)           busy_q <= 1'b0;
    end
  end

  // R4
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alg_done |=> ctl_q.flag);
  // R10
  done_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alg_done && sw_clr) |=> ctl_q.flag);
  // R12
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !alg_done) |=> !ctl_q.flag);
  // R5
  one_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && wdata[B_FLAG] && !alg_done && !start) |=> $stable(ctl_q.flag));
endmodule

// File: rtl/flash_ctl_status.sv
module flash_ctl_status #(
  parameter int          ADDR_W   = 24,
  parameter int          BANK_W   = 8,
  parameter logic [23:0] REG_ADDR = 24'h0000AE,
  parameter logic [7:0]  BANK_LO  = 8'hF8,
  parameter logic [7:0]  BANK_HI  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  output logic [7:0]        bus_rdata,
  input  logic              alg_done,
  input  logic              flash_ready,
  output logic              irq,
  output logic              flash_we
);
  import flcs_pkg::*;

  logic              hit_wr, hit_rd, busy_q;
  logic [BANK_W-1:0] bank;
  ctl_t              ctl_q;

  assign bank = bus_addr[ADDR_W-1 -: BANK_W];

  flcs_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .hit_wr(hit_wr), .hit_rd(hit_rd));

  flcs_gate #(.BANK_W(BANK_W), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)) u_gate (
    .clk(clk), .rst_n(rst_n), .bank(bank), .wr(bus_wr), .we_en(ctl_q.we),
    .busy(busy_q), .start(flash_we));

  flcs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .wdata(bus_wdata),
    .alg_done(alg_done), .start(flash_we), .ctl_q(ctl_q), .busy_q(busy_q));

  assign bus_rdata = hit_rd ? pack_status(ctl_q, flash_ready, bus_rmw) : '0;
  assign irq       = ctl_q.ie && ctl_q.flag;

  // R9
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !flash_we);
  // R7
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.ie |-> !irq);
  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_flash_ctl_status.sv
`timescale 1ns/1ps
module test_flash_ctl_status;
  localparam logic [23:0] REG = 24'h0000AE;

  logic        clk = 0, rst_n = 0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        bus_wr = 0, bus_rd = 0, bus_rmw = 0, alg_done = 0, flash_ready = 1;
  logic        irq, flash_we;

  always #2.5 clk = ~clk;

  flash_ctl_status i_flash_ctl_status (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  // bench model
  logic m_ie = 0, m_flag = 0, m_we = 0, m_busy = 0;
  logic [3:0] m_rsv = 0;
  logic [7:0] e_rd, c_rd;
  logic e_fwe, c_fwe, e_irq, c_irq;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [23:0] a, input logic [7:0] d, input logic w, r, m, dn);
    logic st, hit;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; bus_rmw = m; alg_done = dn;
    hit  = w && (a == REG);
    st   = w && (a[23:16] >= 8'hF8) && m_we && !m_busy;
    e_fwe = st;
    e_irq = m_ie & m_flag;
    e_rd  = (r && a == REG) ? {m_ie, m_flag | m, m_we, flash_ready, m_rsv} : 8'h00;
    #1;
    c_rd = bus_rdata; c_fwe = flash_we; c_irq = irq;
    @(posedge clk);
    if (hit) begin m_ie = d[7]; m_we = d[5]; m_rsv = d[3:0]; end
    if (dn) m_flag = 1;
    else if (st || (hit && !d[6])) m_flag = 0;
    if (st) m_busy = 1; else if (dn) m_busy = 0;
  endtask

  task automatic rd_reg(input logic m, input string tag);
    cyc(REG, 8'h00, 0, 1, m, 0);
    chk(tag, c_rd, e_rd);
    chk({tag, " irq R7"}, {7'd0, c_irq}, {7'd0, e_irq});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset state
    rd_reg(0, "R1 reset");
    chk("R1 reset value", c_rd, 8'h10);
    chk("R1 strobe", {7'd0, c_fwe}, 8'h00);
    flash_ready = 0; rd_reg(0, "R3 ready low");
    cyc(REG, 8'h10, 1, 0, 0, 0); rd_reg(0, "R3 write ignored");
    flash_ready = 1; rd_reg(0, "R3 ready high");
    // all write values, flag set first then flag clear
    for (int v = 0; v < 256; v++) begin
      cyc(REG, 8'h00, 0, 0, 0, 1);
      rd_reg(0, "R4 flag set");
      cyc(REG, v[7:0], 1, 0, 0, 0);
      rd_reg(0, "R2 R5 readback");
      rd_reg(1, "R6 rmw read");
      cyc(REG, v[7:0] & 8'hBF, 1, 0, 0, 0);
      cyc(REG, v[7:0], 1, 0, 0, 0);
      rd_reg(0, "R5 one ignored");
    end
    // collision of completion and clearing write
    cyc(REG, 8'h80, 1, 0, 0, 1);
    rd_reg(0, "R10 collision");
    chk("R10 flag", c_rd & 8'h40, 8'h40);
    // address decode
    for (int k = 0; k < 24; k++) begin
      cyc(REG ^ (24'd1 << k), 8'h2F, 1, 1, 0, 0);
      chk("R11 other read", c_rd, 8'h00);
      rd_reg(0, "R11 unchanged");
    end
    cyc(REG, 8'h00, 0, 0, 0, 0);
    chk("R11 no rd", c_rd, 8'h00);
    // strobe gating, enable off then on (with interrupt enable)
    cyc(REG, 8'h80, 1, 0, 0, 0);
    for (int b = 0; b < 256; b++) begin
      cyc({b[7:0], 16'h0123}, 8'h55, 1, 0, 0, 0);
      chk("R8 disabled", {7'd0, c_fwe}, 8'h00);
    end
    cyc(REG, 8'hA0, 1, 0, 0, 0);
    for (int b = 0; b < 256; b++) begin
      cyc({b[7:0], 16'h4000}, 8'h55, 1, 0, 0, 0);
      chk("R8 window", {7'd0, c_fwe}, {7'd0, e_fwe});
      if (b >= 8'hF8) begin
        chk("R8 fired", {7'd0, c_fwe}, 8'h01);
        cyc({b[7:0], 16'h4001}, 8'h55, 1, 0, 0, 0);
        chk("R9 blocked", {7'd0, c_fwe}, 8'h00);
        rd_reg(0, "R12 cleared");
        chk("R12 flag zero", c_rd & 8'h40, 8'h00);
        cyc(REG, 8'h00, 0, 0, 0, 1);
        rd_reg(0, "R4 done");
        chk("R7 irq on", {7'd0, c_irq}, 8'h01);
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule